// File: doc/BRIEF.md
# Bus-Fault Status and Address Register Gate

This unit holds the bus-fault status bits and the faulting address for a processor core that runs in a secure and a non-secure state. It answers register reads and writes of byte, halfword or word size. Every access carries a secure/non-secure tag. Two status words are kept, one per security state. The bus-fault field, bits [15:8], is physically shared between the two states and is stored only in the non-secure word. A single fault address register sits next to them.

An input control bit, `ns_bf_visible`, decides whether non-secure software may observe or disturb bus-fault information. When that bit is low, a non-secure access sees the shared field as zero and cannot clear it. The same access also finds the fault address register reading zero and ignoring writes. Status bits are cleared by writing ones. They are only raised through a dedicated fault-report port, which also loads the fault address.

Reads are answered on the cycle after the access. An access to an unmapped offset returns zero and raises an error flag.

Top module: `bf_gate`

## Requirements
- R1: After reset both status words and the fault address register are zero, and every mapped read returns 0 with `rd_err` low.
- R2: A read of the status word returns the requester's own status word, with bits [15:8] taken from the shared field held in the non-secure word. A secure word never holds bits [15:8] of its own.
- R3: A non-secure read of the status word while `ns_bf_visible` is 0 returns bits [15:8] as zero. The other bits of the non-secure word still read normally.
- R4: A non-secure write while `ns_bf_visible` is 0 leaves bits [15:8] unchanged, but still clears the other written bits of the non-secure word.
- R5: While `ns_bf_visible` is 0, a non-secure read of the fault address register returns 0 and a non-secure write to it has no effect. Secure accesses, and non-secure accesses while the bit is 1, read the register and write the selected byte lanes.
- R6: A status write clears each bit where the placed write data holds a 1. It clears the requester's word and never sets a bit.
- R7: A secure write with ones in bits [15:8] clears those bits of the shared field. Afterwards they read as zero from both states.
- R8: The status word sits at byte offset 0xD28 and the fault address at 0xD38, with offset bits [1:0] giving the byte lane. `acc_size` 0 means byte, 1 means halfword, 2 or 3 means word. Write data and read data sit at bit 0 and are shifted by 8 times the byte lane. Bits shifted past bit 31 are dropped.
- R9: A fault report ORs `flt_bits[15:8]` into the shared field whatever its tag is. The other bits go into the status word named by `flt_secure`. When `flt_addr_load` is 1, the report also loads `flt_addr` into the fault address register.
- R10: When a fault report and a clearing write hit the same bit in one cycle, the bit ends up set. When a fault address load and an address register write fall in one cycle, the loaded fault address wins.
- R11: An access whose word offset is neither register returns 0 with `rd_err` high and changes no stored state.
- R12: `rd_valid` is high in exactly the cycle after each read access, and `rd_data` and `rd_err` belong to that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_secure | input | 1 | Security tag of the access, 1 = secure |
| acc_offset | input | 12 | Byte offset of the access |
| acc_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| acc_wdata | input | 32 | Write data, right-aligned |
| ns_bf_visible | input | 1 | 1 = non-secure code may see and clear bus-fault state |
| flt_valid | input | 1 | Fault report this cycle |
| flt_secure | input | 1 | Security state the report is attributed to |
| flt_bits | input | 32 | Status bits to raise |
| flt_addr_load | input | 1 | Load the fault address with this report |
| flt_addr | input | 32 | Faulting address |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read data, right-aligned |
| rd_err | output | 1 | Access went to an unmapped offset |

## Verification
Two pairs of functions can land in the same cycle. The first is a fault report and a clearing write to the same status bit. The second is a fault address load and a software write to the address register. The bench drives both pairs at one clock edge on purpose. It reads back through the normal read path and expects the reported bit to stay set and the loaded fault address to win. A second variant clears one bit while raising a different one, to show that the two paths merge by bit and do not block each other.

// File: rtl/bf_gate_pkg.sv
package bf_gate_pkg;
  localparam int DW     = 32;
  localparam int SH_LO  = 8;
  localparam int SH_HI  = 15;
  localparam logic [DW-1:0] SHARED_MASK =
    DW'(((64'd1 << (SH_HI + 1)) - 64'd1) ^ ((64'd1 << SH_LO) - 64'd1));

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRD2 = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_STAT = 2'b01,
    TGT_ADDR = 2'b10
  } tgt_e;

  // Lanes covered by an access of the given size at a byte lane.
  function automatic logic [DW-1:0] lane_mask(input logic [1:0] sz,
                                               input logic [1:0] boff);
    logic [DW-1:0] m;
    case (sz)
      2'b00:   m = {{(DW-8){1'b0}}, 8'hFF};
      2'b01:   m = {{(DW-16){1'b0}}, 16'hFFFF};
      default: m = '1;
    endcase
    return m << {boff, 3'b000};
  endfunction

  // Move right-aligned write data into its lanes.
  function automatic logic [DW-1:0] place(input logic [DW-1:0] d,
                                          input logic [1:0] sz,
                                          input logic [1:0] boff);
    return (d << {boff, 3'b000}) & lane_mask(sz, boff);
  endfunction

  // Pull the accessed lanes of a word down to bit 0.
  function automatic logic [DW-1:0] pick(input logic [DW-1:0] w,
                                         input logic [1:0] sz,
                                         input logic [1:0] boff);
    return (w >> {boff, 3'b000}) & lane_mask(sz, 2'b00);
  endfunction
endpackage

// File: rtl/bf_gate_decode.sv
module bf_gate_decode
  import bf_gate_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter logic [OFF_W-1:0] STAT_OFS = 12'hD28,
  parameter logic [OFF_W-1:0] ADDR_OFS = 12'hD38
) (
  input  logic [OFF_W-1:0] offset,
  output tgt_e             tgt,
  output logic [1:0]       boff
);
  localparam int WA_W = OFF_W - 2;
  logic [WA_W-1:0] word_addr;

  assign word_addr = offset[OFF_W-1:2];
  assign boff      = offset[1:0];

  always_comb begin
    if (word_addr == STAT_OFS[OFF_W-1:2])      tgt = TGT_STAT;
    else if (word_addr == ADDR_OFS[OFF_W-1:2]) tgt = TGT_ADDR;
    else                                       tgt = TGT_NONE;
  end
endmodule

// File: rtl/bf_gate_wpath.sv
module bf_gate_wpath
  import bf_gate_pkg::*;
(
  input  logic          wr_en,
  input  logic          secure,
  input  logic          visible,
  input  tgt_e          tgt,
  input  logic [1:0]    boff,
  input  logic [1:0]    sz,
  input  logic [DW-1:0] wdata,
  input  logic          flt_valid,
  input  logic          flt_secure,
  input  logic [DW-1:0] flt_bits,
  output logic [DW-1:0] clr_s,
  output logic [DW-1:0] clr_ns,
  output logic [DW-1:0] set_s,
  output logic [DW-1:0] set_ns,
  output logic          addr_we,
  output logic [DW-1:0] addr_lanes,
  output logic [DW-1:0] addr_wval,
  output logic          ns_hidden
);
  logic [DW-1:0] placed;
  logic [DW-1:0] gated;

  assign ns_hidden = !secure && !visible;
  assign placed    = place(wdata, sz, boff);
  assign gated     = ns_hidden ? (placed & ~SHARED_MASK) : placed;

  always_comb begin
    clr_s  = '0;
    clr_ns = '0;
    if (wr_en && tgt == TGT_STAT) begin
      if (secure) begin
        clr_s  = gated & ~SHARED_MASK;
        clr_ns = gated & SHARED_MASK;
      end else begin
        clr_ns = gated;
      end
    end
  end

  always_comb begin
    set_s  = '0;
    set_ns = '0;
    if (flt_valid) begin
      set_ns = flt_bits & SHARED_MASK;
      if (flt_secure) set_s  = flt_bits & ~SHARED_MASK;
      else            set_ns = flt_bits;
    end
  end

  assign addr_we    = wr_en && tgt == TGT_ADDR && !ns_hidden;
  assign addr_lanes = lane_mask(sz, boff);
  assign addr_wval  = placed;
endmodule

// File: rtl/bf_gate_store.sv
module bf_gate_store
  import bf_gate_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] clr_s,
  input  logic [DW-1:0] clr_ns,
  input  logic [DW-1:0] set_s,
  input  logic [DW-1:0] set_ns,
  input  logic          addr_we,
  input  logic [DW-1:0] addr_lanes,
  input  logic [DW-1:0] addr_wval,
  input  logic          addr_load,
  input  logic [DW-1:0] addr_ld_val,
  output logic [DW-1:0] stat_s_q,
  output logic [DW-1:0] stat_ns_q,
  output logic [DW-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_s_q  <= '0;
      stat_ns_q <= '0;
      addr_q    <= '0;
    end else begin
      stat_s_q  <= ((stat_s_q & ~clr_s) | set_s) & ~SHARED_MASK;
      stat_ns_q <= (stat_ns_q & ~clr_ns) | set_ns;
      if (addr_load)    addr_q <= addr_ld_val;
      else if (addr_we) addr_q <= (addr_q & ~addr_lanes) | (addr_wval & addr_lanes);
    end
  end

  // R6
  nonset_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_s) == '0 |-> (stat_s_q & ~$past(stat_s_q)) == '0);
  // R6
  nonset_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_ns) == '0 |-> (stat_ns_q & ~$past(stat_ns_q)) == '0);
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ns_q & $past(set_ns)) == $past(set_ns));
  // R2
  s_no_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_s_q & SHARED_MASK) == '0);
endmodule

// File: rtl/bf_gate_rpath.sv
module bf_gate_rpath
  import bf_gate_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          secure,
  input  logic          hidden,
  input  tgt_e          tgt,
  input  logic [1:0]    boff,
  input  logic [1:0]    sz,
  input  logic [DW-1:0] stat_s_q,
  input  logic [DW-1:0] stat_ns_q,
  input  logic [DW-1:0] addr_q,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_err
);
  logic [DW-1:0] stat_view;
  logic [DW-1:0] word;

  always_comb begin
    stat_view = secure ? stat_s_q : stat_ns_q;
    stat_view = stat_view & ~SHARED_MASK;
    if (!hidden) stat_view = stat_view | (stat_ns_q & SHARED_MASK);
  end

  always_comb begin
    case (tgt)
      TGT_STAT: word = stat_view;
      TGT_ADDR: word = hidden ? '0 : addr_q;
      default:  word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_err   <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? pick(word, sz, boff) : '0;
      rd_err   <= rd_en && tgt == TGT_NONE;
    end
  end
endmodule

// File: rtl/bf_gate.sv
module bf_gate
  import bf_gate_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter logic [OFF_W-1:0] STAT_OFS = 12'hD28,
  parameter logic [OFF_W-1:0] ADDR_OFS = 12'hD38
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_secure,
  input  logic [OFF_W-1:0] acc_offset,
  input  logic [1:0]       acc_size,
  input  logic [DW-1:0]    acc_wdata,
  input  logic             ns_bf_visible,
  input  logic             flt_valid,
  input  logic             flt_secure,
  input  logic [DW-1:0]    flt_bits,
  input  logic             flt_addr_load,
  input  logic [DW-1:0]    flt_addr,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             rd_err
);
  tgt_e          tgt;
  logic [1:0]    boff;
  logic          wr_en, rd_en, ns_hidden;
  logic [DW-1:0] clr_s, clr_ns, set_s, set_ns;
  logic          addr_we;
  logic [DW-1:0] addr_lanes, addr_wval;
  logic [DW-1:0] stat_s_q, stat_ns_q, addr_q;
  logic          hidden_addr_rd, hidden_addr_wr, unmapped_wr;

  assign wr_en = acc_valid && acc_write;
  assign rd_en = acc_valid && !acc_write;

  bf_gate_decode #(.OFF_W(OFF_W), .STAT_OFS(STAT_OFS), .ADDR_OFS(ADDR_OFS)) u_dec (
    .offset(acc_offset), .tgt(tgt), .boff(boff)
  );

  bf_gate_wpath u_wp (
    .wr_en(wr_en), .secure(acc_secure), .visible(ns_bf_visible), .tgt(tgt),
    .boff(boff), .sz(acc_size), .wdata(acc_wdata),
    .flt_valid(flt_valid), .flt_secure(flt_secure), .flt_bits(flt_bits),
    .clr_s(clr_s), .clr_ns(clr_ns), .set_s(set_s), .set_ns(set_ns),
    .addr_we(addr_we), .addr_lanes(addr_lanes), .addr_wval(addr_wval),
    .ns_hidden(ns_hidden)
  );

  bf_gate_store u_st (
    .clk(clk), .rst_n(rst_n), .clr_s(clr_s), .clr_ns(clr_ns),
    .set_s(set_s), .set_ns(set_ns), .addr_we(addr_we),
    .addr_lanes(addr_lanes), .addr_wval(addr_wval),
    .addr_load(flt_valid && flt_addr_load), .addr_ld_val(flt_addr),
    .stat_s_q(stat_s_q), .stat_ns_q(stat_ns_q), .addr_q(addr_q)
  );

  bf_gate_rpath u_rp (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .secure(acc_secure),
    .hidden(ns_hidden), .tgt(tgt), .boff(boff), .sz(acc_size),
    .stat_s_q(stat_s_q), .stat_ns_q(stat_ns_q), .addr_q(addr_q),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err)
  );

  assign hidden_addr_rd = rd_en && ns_hidden && tgt == TGT_ADDR;
  assign hidden_addr_wr = wr_en && ns_hidden && tgt == TGT_ADDR;
  assign unmapped_wr    = wr_en && tgt == TGT_NONE;

  // R12
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == $past(rd_en));
  // R11
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_valid && rd_data == '0));
  // R5
  hid_addr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hidden_addr_rd) |-> rd_data == '0);
  // R5
  hid_addr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hidden_addr_wr && !(flt_valid && flt_addr_load)) |-> addr_q == $past(addr_q));
  // R11
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(unmapped_wr && !flt_valid) |->
      (stat_s_q == $past(stat_s_q) && stat_ns_q == $past(stat_ns_q)));
endmodule

// File: tb/tb_bf_gate.sv
module tb_bf_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 0, acc_write = 0, acc_secure = 0;
  logic [11:0] acc_offset = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic        ns_bf_visible = 0;
  logic        flt_valid = 0, flt_secure = 0, flt_addr_load = 0;
  logic [31:0] flt_bits = '0, flt_addr = '0;
  logic        rd_valid, rd_err;
  logic [31:0] rd_data;
  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [11:0] ST = 12'hD28;
  localparam logic [11:0] AD = 12'hD38;

  always #2 clk = ~clk;

  bf_gate dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_secure(acc_secure), .acc_offset(acc_offset), .acc_size(acc_size),
    .acc_wdata(acc_wdata), .ns_bf_visible(ns_bf_visible),
    .flt_valid(flt_valid), .flt_secure(flt_secure), .flt_bits(flt_bits),
    .flt_addr_load(flt_addr_load), .flt_addr(flt_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input bit sec, input bit vis,
                     input logic [11:0] off, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_secure = sec; ns_bf_visible = vis;
    acc_offset = off; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd_chk(input string req, input bit sec, input bit vis,
                        input logic [11:0] off, input logic [1:0] sz,
                        input logic [31:0] exp, input bit exp_err);
    acc(0, sec, vis, off, sz, '0);
    chk(req, rd_data, exp);
    chk({req, " err"}, {31'b0, rd_err}, {31'b0, exp_err});
    chk({req, " valid"}, {31'b0, rd_valid}, 32'd1);
  endtask

  task automatic fault(input bit sec, input logic [31:0] bits, input bit ld, input logic [31:0] a);
    @(negedge clk);
    flt_valid = 1; flt_secure = sec; flt_bits = bits; flt_addr_load = ld; flt_addr = a;
    @(negedge clk);
    flt_valid = 0; flt_addr_load = 0; flt_bits = '0;
  endtask

  task automatic t_reset;
    rd_chk("R1 status s", 1, 0, ST, 2'd2, 32'h0, 0);
    rd_chk("R1 status ns", 0, 1, ST, 2'd2, 32'h0, 0);
    rd_chk("R1 addr", 1, 0, AD, 2'd2, 32'h0, 0);
  endtask

  task automatic t_set_and_views;
    fault(1, 32'h0000_8201, 0, '0);
    rd_chk("R9 R2 secure word", 1, 0, ST, 2'd2, 32'h0000_8201, 0);
    rd_chk("R3 ns hidden word", 0, 0, ST, 2'd2, 32'h0, 0);
    rd_chk("R2 ns visible word", 0, 1, ST, 2'd2, 32'h0000_8200, 0);
    rd_chk("R8 byte lane1", 1, 0, ST + 12'd1, 2'd0, 32'h82, 0);
    rd_chk("R8 half lane0", 1, 0, ST, 2'd1, 32'h8201, 0);
    fault(0, 32'h0001_0004, 0, '0);
    rd_chk("R9 ns visible", 0, 1, ST, 2'd2, 32'h0001_8204, 0);
    rd_chk("R3 ns hidden keeps low", 0, 0, ST, 2'd2, 32'h0001_0004, 0);
    rd_chk("R8 byte lane2", 0, 1, ST + 12'd2, 2'd0, 32'h01, 0);
  endtask

  task automatic t_clears;
    acc(1, 0, 0, ST, 2'd2, 32'hFFFF_FFFF);
    rd_chk("R4 hidden clear keeps shared", 0, 1, ST, 2'd2, 32'h0000_8200, 0);
    rd_chk("R6 secure unaffected", 1, 0, ST, 2'd2, 32'h0000_8201, 0);
    acc(1, 1, 0, ST + 12'd1, 2'd0, 32'h02);
    rd_chk("R7 secure clears shared, secure view", 1, 0, ST, 2'd2, 32'h0000_8001, 0);
    rd_chk("R7 secure clears shared, ns view", 0, 1, ST, 2'd2, 32'h0000_8000, 0);
    acc(1, 0, 1, ST + 12'd1, 2'd0, 32'h80);
    rd_chk("R6 ns visible clear", 1, 0, ST, 2'd2, 32'h0000_0001, 0);
    acc(1, 1, 0, ST, 2'd2, 32'h0);
    rd_chk("R6 zero write no change", 1, 0, ST, 2'd2, 32'h0000_0001, 0);
  endtask

  task automatic t_addr;
    fault(1, 32'h0, 1, 32'hDEAD_BEEF);
    rd_chk("R9 addr load", 1, 0, AD, 2'd2, 32'hDEAD_BEEF, 0);
    rd_chk("R5 hidden addr read", 0, 0, AD, 2'd2, 32'h0, 0);
    acc(1, 0, 0, AD, 2'd2, 32'h1234_5678);
    rd_chk("R5 hidden addr write", 1, 0, AD, 2'd2, 32'hDEAD_BEEF, 0);
    acc(1, 0, 1, AD, 2'd2, 32'h1234_5678);
    rd_chk("R5 visible addr write", 0, 1, AD, 2'd2, 32'h1234_5678, 0);
    acc(1, 1, 0, AD + 12'd2, 2'd1, 32'h0000_AAAA);
    rd_chk("R8 half write lane2", 1, 0, AD, 2'd2, 32'hAAAA_5678, 0);
    rd_chk("R8 byte read lane3", 1, 0, AD + 12'd3, 2'd0, 32'hAA, 0);
  endtask

  task automatic t_unmapped;
    rd_chk("R11 unmapped read", 1, 0, 12'hD30, 2'd2, 32'h0, 1);
    acc(1, 1, 1, 12'hD30, 2'd2, 32'hFFFF_FFFF);
    chk("R11 unmapped write err", {31'b0, rd_err}, 32'd0);
    rd_chk("R11 unmapped write no effect", 1, 0, ST, 2'd2, 32'h0000_0001, 0);
    @(negedge clk);
    chk("R12 no read no valid", {31'b0, rd_valid}, 32'd0);
  endtask

  task automatic t_collide;
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_secure = 1; ns_bf_visible = 0;
    acc_offset = ST; acc_size = 2'd2; acc_wdata = 32'h0000_0001;
    flt_valid = 1; flt_secure = 1; flt_bits = 32'h0000_0001;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; flt_valid = 0; flt_bits = '0;
    rd_chk("R10 set beats clear", 1, 0, ST, 2'd2, 32'h0000_0001, 0);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_secure = 1;
    acc_offset = ST; acc_size = 2'd2; acc_wdata = 32'h0000_0001;
    flt_valid = 1; flt_secure = 1; flt_bits = 32'h0000_0002;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; flt_valid = 0; flt_bits = '0;
    rd_chk("R10 clear and set other bit", 1, 0, ST, 2'd2, 32'h0000_0002, 0);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_secure = 1;
    acc_offset = AD; acc_size = 2'd2; acc_wdata = 32'h5555_5555;
    flt_valid = 1; flt_secure = 1; flt_addr_load = 1; flt_addr = 32'h0BAD_F00D;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; flt_valid = 0; flt_addr_load = 0;
    rd_chk("R10 fault addr beats write", 1, 0, AD, 2'd2, 32'h0BAD_F00D, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_set_and_views();
    t_clears();
    t_addr();
    t_unmapped();
    t_collide();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule